// File: doc/BRIEF.md
# Sampled ON/OFF Switching Cycle Controller

This block decides, for every period of an external switching oscillator, whether the power switch conducts in that period and when the conduction stops. The feedback enable level is sampled once, at the rising edge of the cycle-start signal. A sampled high starts a conduction pulse. A sampled low leaves the gate off until the next cycle start. Changes on the enable line between two samples have no effect. Once a pulse has started, it ends only through the normal termination paths.

A pulse ends for one of four reasons. The first is the current-limit comparator tripping once the leading-edge blanking window has expired. The second is the maximum-duty signal going low, but only while on-time extension is inactive. The third is a new cycle start. The fourth is the global disable. On-time extension stays off from reset until the first regulation-reached indication, and it stays on after that. After that point, a pulse ignores maximum duty and runs until the current limit trips or the cycle ends.

At every gate fall the block measures how long the pulse lasted. If the pulse was shorter than a programmable threshold, it raises a short-conduction flag, which the oscillator can use to lower the switching frequency. An enabled-cycle strobe marks each cycle whose sample was high, for use by downstream load-sequence counters. All inputs are assumed synchronous to the system clock.

Top module: `cycle_gate_ctrl`

## Requirements
- R1: While `rst` is high, `gate`, `en_strobe` and `short_on` are driven low at every clock edge.
- R2: At the clock edge that first sees `cyc_start` high after it was low, with the gate idle, `gate` rises in that same edge if `en_fb` is 1 and `force_off` is 0. Otherwise `gate` stays low for the whole cycle.
- R3: Changes on `en_fb` at any edge other than a cycle-start edge neither start nor stop a pulse.
- R4: Let N be the number of clock periods `gate` has been high, counted at the current edge. When `ilim_trip` is high and N >= BLANK_TICKS, `gate` falls at that edge. When N < BLANK_TICKS, a high `ilim_trip` is ignored.
- R5: While extension is inactive, `dmax` low at an edge with `gate` high makes `gate` fall at that edge.
- R6: Extension becomes active at the edge after `reg_ok` is first seen high and then stays active until reset. While extension is active, `dmax` low does not end a pulse.
- R7: At every fall of `gate`, `short_on` is set to 1 if the pulse lasted fewer than SHORT_TICKS clock periods and to 0 otherwise. Between falls, `short_on` holds its value.
- R8: `en_strobe` is high for exactly one clock at each cycle-start edge where `en_fb` is 1, including cycles where the gate is held off. It is low at all other times.
- R9: A cycle start while `gate` is high ends the pulse. `gate` is then low for exactly one clock and rises again at the following edge if the new sample was 1.
- R10: While `force_off` is high, `gate` is low from the next edge on, and no pulse starts. A pulse that was stopped this way does not resume within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Oscillator cycle clock; a new cycle begins at its rising edge |
| dmax | input | 1 | Maximum-duty window, high while conduction is allowed |
| en_fb | input | 1 | Feedback enable level, high requests a pulse |
| ilim_trip | input | 1 | Current-limit comparator output |
| reg_ok | input | 1 | Output-in-regulation indication, arms on-time extension |
| force_off | input | 1 | Global disable, holds the gate low |
| gate | output | 1 | Registered gate drive |
| en_strobe | output | 1 | One-clock pulse per cycle sampled enabled |
| short_on | output | 1 | Last pulse was shorter than SHORT_TICKS clocks |

## Verification
`gate` and `en_strobe` change in the same clock edge that first sees the rising `cyc_start`. A current-limit trip, a falling `dmax` or a raised `force_off` takes effect at the first edge that samples it. `reg_ok` alters pulse termination only from the edge after it is sampled. `short_on` is updated in the edge where `gate` falls. The bench changes inputs on falling clock edges and advances a behavioural model on rising edges. It compares all three outputs against that model at every falling edge, so each result is checked in the first half-period after the edge where it is due. Pulse lengths are chosen on both sides of the blanking and short-conduction thresholds.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

  typedef enum logic [1:0] {
    CGC_IDLE = 2'd0,
    CGC_ON   = 2'd1,
    CGC_ARM  = 2'd2
  } cgc_state_e;

  function automatic int cgc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cgc_edge.sv
module cgc_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sig_in,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_in;
  end

  assign rise = sig_in & ~sig_q;

endmodule

// File: rtl/cgc_ext_latch.sv
module cgc_ext_latch (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  output logic active
);

  always_ff @(posedge clk) begin
    if (rst)      active <= 1'b0;
    else if (arm) active <= 1'b1;
  end

endmodule

// File: rtl/cgc_ontime.sv
module cgc_ontime #(
  parameter int BLANK_TICKS = 8,
  parameter int SHORT_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic blank_done,
  output logic short_hit
);

  import cgc_pkg::*;

  localparam int CNT_MAX = cgc_max(BLANK_TICKS, SHORT_TICKS) + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] MAX_C   = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_TICKS);

  logic [CNT_W-1:0] cnt;

  // cnt holds the number of periods the gate has been high, seen at an edge
  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= CNT_W'(1);
    else if (run && cnt != MAX_C) cnt <= cnt + CNT_W'(1);
  end

  generate
    if (BLANK_TICKS == 0) begin : g_noblank
      assign blank_done = 1'b1;
    end else begin : g_blank
      localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK_TICKS);
      assign blank_done = (cnt >= BLANK_C);
    end
  endgenerate

  assign short_hit = (cnt < SHORT_C);

endmodule

// File: rtl/cgc_fsm.sv
module cgc_fsm (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic en_fb,
  input  logic dmax,
  input  logic ilim_trip,
  input  logic ext_active,
  input  logic force_off,
  input  logic blank_done,
  input  logic short_hit,
  output logic gate,
  output logic en_strobe,
  output logic short_on,
  output logic load
);

  import cgc_pkg::*;

  cgc_state_e state, state_n;
  logic gate_n, short_n, ends;

  assign ends = force_off || start || (ilim_trip && blank_done) || (!dmax && !ext_active);

  always_comb begin
    state_n = state;
    gate_n  = gate;
    short_n = short_on;
    load    = 1'b0;
    unique case (state)
      CGC_IDLE: begin
        if (start && en_fb && !force_off) begin
          state_n = CGC_ON;
          gate_n  = 1'b1;
          load    = 1'b1;
        end
      end
      CGC_ON: begin
        if (ends) begin
          gate_n  = 1'b0;
          short_n = short_hit;
          state_n = (start && en_fb && !force_off) ? CGC_ARM : CGC_IDLE;
        end
      end
      CGC_ARM: begin
        if (force_off) begin
          state_n = CGC_IDLE;
        end else begin
          state_n = CGC_ON;
          gate_n  = 1'b1;
          load    = 1'b1;
        end
      end
      default: begin
        state_n = CGC_IDLE;
        gate_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= CGC_IDLE;
      gate      <= 1'b0;
      short_on  <= 1'b0;
      en_strobe <= 1'b0;
    end else begin
      state     <= state_n;
      gate      <= gate_n;
      short_on  <= short_n;
      en_strobe <= start && en_fb;
    end
  end

endmodule

// File: rtl/cycle_gate_ctrl.sv
module cycle_gate_ctrl #(
  parameter int BLANK_TICKS = 8,
  parameter int SHORT_TICKS = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic dmax,
  input  logic en_fb,
  input  logic ilim_trip,
  input  logic reg_ok,
  input  logic force_off,
  output logic gate,
  output logic en_strobe,
  output logic short_on
);

  logic start, ext_active, blank_done, short_hit, load;

  cgc_edge #(.WIDTH(1)) u_edge (
    .clk(clk), .rst(rst), .sig_in(cyc_start), .rise(start)
  );

  cgc_ext_latch u_ext (
    .clk(clk), .rst(rst), .arm(reg_ok), .active(ext_active)
  );

  cgc_ontime #(.BLANK_TICKS(BLANK_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_ontime (
    .clk(clk), .rst(rst), .load(load), .run(gate),
    .blank_done(blank_done), .short_hit(short_hit)
  );

  cgc_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .en_fb(en_fb), .dmax(dmax),
    .ilim_trip(ilim_trip), .ext_active(ext_active), .force_off(force_off),
    .blank_done(blank_done), .short_hit(short_hit),
    .gate(gate), .en_strobe(en_strobe), .short_on(short_on), .load(load)
  );

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
  parameter int BLANK_TICKS = 8
) (
  input logic clk,
  input logic rst,
  input logic cyc_start,
  input logic dmax,
  input logic ilim_trip,
  input logic force_off,
  input logic gate,
  input logic en_strobe,
  input logic short_on
);

  logic [15:0] ck_on;
  logic        ck_cyc;
  logic        ck_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_on  <= 16'd1;
      ck_cyc <= 1'b0;
    end else begin
      ck_cyc <= cyc_start;
      if (!gate)                 ck_on <= 16'd1;
      else if (ck_on != 16'hFFFF) ck_on <= ck_on + 16'd1;
    end
  end

  assign ck_start = cyc_start && !ck_cyc;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!gate && !en_strobe && !short_on));

  assert_rise_needs_sample_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> (en_strobe || $past(en_strobe)));

  assert_trip_ends_R4: assert property (@(posedge clk) disable iff (rst)
    (gate && ilim_trip && ck_on >= 16'(BLANK_TICKS)) |=> !gate);

  assert_blank_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (gate && ck_on < 16'(BLANK_TICKS) && dmax && !force_off && !ck_start) |=> gate);

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (rst)
    en_strobe |=> !en_strobe);

  assert_restart_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (gate && ck_start) |=> !gate);

  assert_force_low_R10: assert property (@(posedge clk) disable iff (rst)
    force_off |=> !gate);

endmodule

bind cycle_gate_ctrl cgc_checker #(.BLANK_TICKS(BLANK_TICKS)) u_cgc_chk (
  .clk(clk), .rst(rst), .cyc_start(cyc_start), .dmax(dmax),
  .ilim_trip(ilim_trip), .force_off(force_off), .gate(gate),
  .en_strobe(en_strobe), .short_on(short_on)
);

// File: tb/cycle_gate_ctrl_bench.sv
module cycle_gate_ctrl_bench;

  localparam int BLANK = 8;
  localparam int SHORT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0, dmax = 1'b0, en_fb = 1'b0, ilim_trip = 1'b0;
  logic reg_ok = 1'b0, force_off = 1'b0;
  logic gate, en_strobe, short_on;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  cycle_gate_ctrl #(.BLANK_TICKS(BLANK), .SHORT_TICKS(SHORT)) u_cycle_gate_ctrl (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .dmax(dmax), .en_fb(en_fb),
    .ilim_trip(ilim_trip), .reg_ok(reg_ok), .force_off(force_off),
    .gate(gate), .en_strobe(en_strobe), .short_on(short_on)
  );

  // behavioural reference model
  bit m_gate, m_arm, m_strobe, m_short, m_ext, m_cprev;
  int m_on;

  always @(posedge clk) begin
    bit st, fin;
    if (rst) begin
      m_gate = 0; m_arm = 0; m_strobe = 0; m_short = 0; m_ext = 0; m_cprev = 0; m_on = 0;
    end else begin
      st = cyc_start && !m_cprev;
      m_strobe = st && en_fb;
      if (m_arm) begin
        m_arm = 0;
        if (!force_off) begin m_gate = 1; m_on = 1; end
      end else if (m_gate) begin
        fin = force_off || st || (ilim_trip && m_on >= BLANK) || (!dmax && !m_ext);
        if (fin) begin
          m_gate = 0;
          m_short = (m_on < SHORT);
          m_arm = st && en_fb && !force_off;
        end else begin
          m_on++;
        end
      end else if (st && en_fb && !force_off) begin
        m_gate = 1; m_on = 1;
      end
      m_ext = m_ext || reg_ok;
      m_cprev = cyc_start;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cur_req, "gate", gate, m_gate);
      chk(cur_req, "en_strobe", en_strobe, m_strobe);
      chk(cur_req, "short_on", short_on, m_short);
    end
  end

  // one oscillator period of len clocks; trip_at < 0 means no trip
  task automatic cycle(input bit en, input int dmax_len, input int trip_at,
                       input bit flip_en, input int len);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      cyc_start = (t < len / 2);
      dmax      = (t < dmax_len);
      ilim_trip = (trip_at >= 0) && (t >= trip_at);
      if (t == 0)          en_fb = en;
      else if (flip_en)    en_fb = (t % 3 == 1) ? ~en : en;
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk("R1", "gate in reset", gate, 1'b0);
      chk("R1", "strobe in reset", en_strobe, 1'b0);
    end
    rst = 1'b0;

    cur_req = "R2";
    cycle(1, 30, -1, 0, 50);
    cycle(0, 30, -1, 0, 50);
    cur_req = "R3";
    cycle(1, 30, -1, 1, 50);
    cycle(0, 30, -1, 1, 50);
    cur_req = "R4";
    cycle(1, 40, 2, 0, 50);
    cycle(1, 40, 12, 0, 50);
    cur_req = "R5";
    cycle(1, 12, -1, 0, 50);
    cur_req = "R7";
    cycle(1, 5, -1, 0, 50);
    cycle(1, 35, -1, 0, 50);
    cycle(1, 35, 9, 0, 50);
    cur_req = "R8";
    cycle(0, 30, -1, 0, 40);
    cycle(1, 30, -1, 0, 40);
    cycle(0, 30, -1, 0, 40);

    cur_req = "R6";
    @(negedge clk); reg_ok = 1'b1;
    @(negedge clk); reg_ok = 1'b0;
    cycle(1, 10, 40, 0, 50);
    cycle(1, 10, 25, 0, 50);
    cur_req = "R9";
    cycle(1, 10, -1, 0, 50);
    cycle(1, 10, -1, 0, 50);
    cycle(0, 10, -1, 0, 50);

    cur_req = "R10";
    fork
      cycle(1, 40, -1, 0, 50);
      begin repeat (6) @(negedge clk); force_off = 1'b1;
            repeat (4) @(negedge clk); force_off = 1'b0; end
    join
    @(negedge clk); force_off = 1'b1;
    cycle(1, 40, -1, 0, 50);
    force_off = 1'b0;
    cycle(1, 40, 20, 0, 50);

    @(negedge clk);
    chk("R7", "flag after long pulse", short_on, 1'b0);
    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "gate after re-reset", gate, 1'b0);
    chk("R1", "short after re-reset", short_on, 1'b0);
    finish_run();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    finish_run();
  end

endmodule